// File: doc/BRIEF.md
# Isochronous Transmit Context Control Bank

This block holds the control and status word for each of eight isochronous transmit DMA contexts in a serial-bus host controller. Software reaches each context through two word addresses. At the set address, every one in the write data turns the matching control bit on. At the clear address, every one turns the matching control bit off. A read from either address returns the context's current word. The DMA engine reports its state on per-context side lines: a descriptor fetch, a fatal error, an active level and a completion code. These lines update the status bits that software cannot write.

Each context also carries its own start gate. When the cycle-match enable of a context is set, the gate stays shut until the running bus cycle stamp equals the context's programmed 15-bit cycle number. The stamp is formed from the two low bits of the seconds count above the 13-bit cycle count. When the context goes active, the enable clears itself. The block outputs a per-context transmit permission, and the descriptor engine uses it together with run, wake and dead.

Top module: `itx_ctx_bank`

## Requirements
- R1: Context n (0..7) has its set address at byte 0x200 + 16·n and its clear address at 0x204 + 16·n. A write to any other address, including offset 8 or 12 inside a context's slot and 0x280 and above, changes no state. A read from any other address returns zero.
- R2: A read from either address of a context returns the word {cme[31], cycle_match[30:16], run[15], 0[14:13], wake[12], dead[11], active[10], 0[9:5], event_code[4:0]}. Bits 14:13 and 9:5 always read zero.
- R3: Run (bit 15) is set by a one at the set address and cleared by a one at the clear address. No hardware line changes it.
- R4: Wake (bit 12) is set by a one at the set address. A write to the clear address has no effect on it. A descriptor fetch pulse clears it. A fetch in the same cycle as a set leaves it clear.
- R5: Dead (bit 11) is set by a fatal-error pulse. It is cleared by a software clear of run. A fatal pulse in the same cycle as a run clear leaves dead set. No software write sets it.
- R6: Active (bit 10) shows the engine's active level one cycle later. Software writes to it have no effect.
- R7: The event code (bits 4:0) is loaded from the engine's code input when its write strobe is high. Software writes to it have no effect.
- R8: Each bit of the cycle-match field (bits 30:16) is set by a one at the set address and cleared by a one at the clear address. Zeros leave it unchanged.
- R9: Cycle-match enable (bit 31) is set and cleared by software. It is cleared by hardware in the cycle in which the context goes from inactive to active. A software set in that same cycle wins.
- R10: The transmit permission of a context is high when run is set, dead is clear, and one of three holds: enable is clear, the stamp {seconds[1:0], count[12:0]} equals the cycle-match field in the current cycle, or it has matched in an earlier cycle since enable was last set.
- R11: During synchronous active-low reset, every bit of every context is zero.
- R12: Each context responds only to its own two addresses and to its own bit of each engine line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| sw_addr_i | input | 12 | Software byte address, used for reads and writes |
| sw_wr_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Word of the addressed context, or zero |
| hw_fetch_i | input | 8 | Per-context descriptor fetch pulse |
| hw_fatal_i | input | 8 | Per-context fatal error pulse |
| hw_active_i | input | 8 | Per-context engine active level |
| hw_evt_wr_i | input | 8 | Per-context event code write strobe |
| hw_evt_code_i | input | 40 | Event codes, 5 bits per context, context n at bits 5n+4:5n |
| cyc_sec_lo_i | input | 2 | Low two bits of the bus cycle seconds count |
| cyc_count_i | input | 13 | Bus cycle count |
| ctx_run_o | output | 8 | Run bit per context |
| ctx_wake_o | output | 8 | Wake bit per context |
| ctx_dead_o | output | 8 | Dead bit per context |
| ctx_tx_allow_o | output | 8 | Transmit permission per context |

## Verification
Three pairs of functions can land in the same cycle: a software set of wake together with a fetch pulse, a software clear of run together with a fatal pulse, and a software set of the cycle-match enable together with the active edge that clears it. The bench drives each pair in one cycle on purpose and reads the word back through the context's address. The read must show the hardware side winning for wake and dead and the software side winning for the enable. A long mixed run then overlaps software writes at random addresses with random engine pulses and a moving cycle stamp, and every cycle is judged against a behavioural model of all eight contexts.

// File: rtl/itx_ctx_pkg.sv
// Package: shared field positions, widths and the per-context state record
// for the isochronous transmit context control bank.
// Assumes a 32-bit register word; field positions are fixed by software.
package itx_ctx_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_W     = 13;
    localparam int SEC_LO_W  = 2;
    localparam int CM_W      = SEC_LO_W + CNT_W;
    localparam int EVT_W     = 5;

    localparam int BIT_CME   = 31;
    localparam int CM_LO     = 16;
    localparam int CM_HI     = CM_LO + CM_W - 1;
    localparam int BIT_RUN   = 15;
    localparam int BIT_WAKE  = 12;
    localparam int BIT_DEAD  = 11;
    localparam int BIT_ACT   = 10;

    typedef struct packed {
        logic              cme;
        logic [CM_W-1:0]   cm;
        logic              run;
        logic              wake;
        logic              dead;
        logic              active;
        logic [EVT_W-1:0]  evt;
    } ctx_state_t;

    // Build the software-visible word; reserved positions read zero.
    function automatic logic [DATA_W-1:0] pack_word(input ctx_state_t s);
        return {s.cme, s.cm, s.run, 2'b00, s.wake, s.dead, s.active,
                5'b00000, s.evt};
    endfunction

endpackage

// File: rtl/itx_addr_decode.sv
// Address decoder: turns a byte address into one-hot selects for the set
// and clear word of each context. Assumes word-aligned addresses; any
// address that is not exactly a set or clear word selects nothing.
module itx_addr_decode #(
    parameter int NUM_CTX    = 8,
    parameter int ADDR_W     = 12,
    parameter int BASE_ADDR  = 'h200,
    parameter int CTX_STRIDE = 16,
    parameter int CLR_OFS    = 4
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [NUM_CTX-1:0] set_sel_o,
    output logic [NUM_CTX-1:0] clr_sel_o
);

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE_ADDR + g * CTX_STRIDE);
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE_ADDR + g * CTX_STRIDE + CLR_OFS);
        // Exact match of the two word addresses belonging to this context.
        assign set_sel_o[g] = (addr_i == SET_A);
        assign clr_sel_o[g] = (addr_i == CLR_A);
    end

endmodule

// File: rtl/itx_cycle_match.sv
// Start gate for one context: opens when cycle matching is off, when the
// bus cycle stamp equals the programmed cycle number, or once it has
// matched since the enable was set. Assumes the stamp is already built
// as {seconds[1:0], count[12:0]}.
module itx_cycle_match
    import itx_ctx_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cme_i,
    input  logic [CM_W-1:0] cm_i,
    input  logic [CM_W-1:0] stamp_i,
    output logic            start_ok_o
);

    logic hit_now;
    logic hit_q;

    // Compare the current bus cycle with the programmed cycle.
    assign hit_now = (stamp_i == cm_i);

    // Remember a match until the enable drops.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      hit_q <= 1'b0;
        else if (!cme_i)  hit_q <= 1'b0;
        else if (hit_now) hit_q <= 1'b1;
    end

    assign start_ok_o = !cme_i || hit_now || hit_q;

endmodule

// File: rtl/itx_ctx_reg.sv
// One context control word. Software owns run, wake-set, cycle-match
// enable and the cycle-match field; the engine owns wake-clear, dead,
// active and the event code. On collisions the engine wins for status
// bits (wake, dead) and software wins for control bits (enable).
// Assumes set and clear strobes are never both high.
module itx_ctx_reg
    import itx_ctx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sw_set_i,
    input  logic              sw_clr_i,
    input  logic [DATA_W-1:0] sw_data_i,
    input  logic              hw_fetch_i,
    input  logic              hw_fatal_i,
    input  logic              hw_active_i,
    input  logic              hw_evt_wr_i,
    input  logic [EVT_W-1:0]  hw_evt_code_i,
    input  logic [CM_W-1:0]   stamp_i,
    output logic [DATA_W-1:0] word_o,
    output logic              run_o,
    output logic              wake_o,
    output logic              dead_o,
    output logic              tx_allow_o
);

    ctx_state_t st_q;
    ctx_state_t st_d;
    logic       act_rise;
    logic       run_clr;
    logic       start_ok;
    logic       unused_wdata;

    assign act_rise     = hw_active_i && !st_q.active;
    assign run_clr      = sw_clr_i && sw_data_i[BIT_RUN];
    assign unused_wdata = ^{sw_data_i[14:13], sw_data_i[11:0]};

    // Next-state rules for every field, with the collision priorities.
    always_comb begin
        st_d = st_q;
        if (sw_set_i && sw_data_i[BIT_RUN]) st_d.run = 1'b1;
        else if (run_clr)                   st_d.run = 1'b0;

        if (sw_set_i && sw_data_i[BIT_CME])      st_d.cme = 1'b1;
        else if (sw_clr_i && sw_data_i[BIT_CME]) st_d.cme = 1'b0;
        else if (act_rise)                       st_d.cme = 1'b0;

        if (sw_set_i)      st_d.cm = st_q.cm | sw_data_i[CM_HI:CM_LO];
        else if (sw_clr_i) st_d.cm = st_q.cm & ~sw_data_i[CM_HI:CM_LO];

        if (hw_fetch_i)                          st_d.wake = 1'b0;
        else if (sw_set_i && sw_data_i[BIT_WAKE]) st_d.wake = 1'b1;

        if (hw_fatal_i)   st_d.dead = 1'b1;
        else if (run_clr) st_d.dead = 1'b0;

        st_d.active = hw_active_i;

        if (hw_evt_wr_i) st_d.evt = hw_evt_code_i;
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    itx_cycle_match u_match (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cme_i      (st_q.cme),
        .cm_i       (st_q.cm),
        .stamp_i    (stamp_i),
        .start_ok_o (start_ok)
    );

    assign word_o     = pack_word(st_q);
    assign run_o      = st_q.run;
    assign wake_o     = st_q.wake;
    assign dead_o     = st_q.dead;
    assign tx_allow_o = st_q.run && !st_q.dead && start_ok;

endmodule

// File: rtl/itx_ctx_bank.sv
// Top: eight isochronous transmit context words behind set/clear
// addresses, with per-context engine update lines and cycle-match start
// gates. Reads are combinational from the address; writes take effect at
// the next clock edge. Assumes one software access per cycle.
module itx_ctx_bank
    import itx_ctx_pkg::*;
#(
    parameter int NUM_CTX    = 8,
    parameter int ADDR_W     = 12,
    parameter int BASE_ADDR  = 'h200,
    parameter int CTX_STRIDE = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [ADDR_W-1:0]        sw_addr_i,
    input  logic                     sw_wr_i,
    input  logic [DATA_W-1:0]        sw_wdata_i,
    output logic [DATA_W-1:0]        sw_rdata_o,
    input  logic [NUM_CTX-1:0]       hw_fetch_i,
    input  logic [NUM_CTX-1:0]       hw_fatal_i,
    input  logic [NUM_CTX-1:0]       hw_active_i,
    input  logic [NUM_CTX-1:0]       hw_evt_wr_i,
    input  logic [NUM_CTX*EVT_W-1:0] hw_evt_code_i,
    input  logic [SEC_LO_W-1:0]      cyc_sec_lo_i,
    input  logic [CNT_W-1:0]         cyc_count_i,
    output logic [NUM_CTX-1:0]       ctx_run_o,
    output logic [NUM_CTX-1:0]       ctx_wake_o,
    output logic [NUM_CTX-1:0]       ctx_dead_o,
    output logic [NUM_CTX-1:0]       ctx_tx_allow_o
);

    logic [NUM_CTX-1:0] set_sel;
    logic [NUM_CTX-1:0] clr_sel;
    logic [CM_W-1:0]    stamp;
    logic [DATA_W-1:0]  word [NUM_CTX];

    assign stamp = {cyc_sec_lo_i, cyc_count_i};

    itx_addr_decode #(
        .NUM_CTX    (NUM_CTX),
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR),
        .CTX_STRIDE (CTX_STRIDE),
        .CLR_OFS    (4)
    ) u_dec (
        .addr_i    (sw_addr_i),
        .set_sel_o (set_sel),
        .clr_sel_o (clr_sel)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        itx_ctx_reg u_reg (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .sw_set_i      (sw_wr_i && set_sel[g]),
            .sw_clr_i      (sw_wr_i && clr_sel[g]),
            .sw_data_i     (sw_wdata_i),
            .hw_fetch_i    (hw_fetch_i[g]),
            .hw_fatal_i    (hw_fatal_i[g]),
            .hw_active_i   (hw_active_i[g]),
            .hw_evt_wr_i   (hw_evt_wr_i[g]),
            .hw_evt_code_i (hw_evt_code_i[g*EVT_W +: EVT_W]),
            .stamp_i       (stamp),
            .word_o        (word[g]),
            .run_o         (ctx_run_o[g]),
            .wake_o        (ctx_wake_o[g]),
            .dead_o        (ctx_dead_o[g]),
            .tx_allow_o    (ctx_tx_allow_o[g])
        );
    end

    // Read mux: the word of whichever context owns the address, else zero.
    always_comb begin
        sw_rdata_o = '0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (set_sel[i] || clr_sel[i]) sw_rdata_o = sw_rdata_o | word[i];
        end
    end

endmodule

// File: rtl/itx_ctx_bank_chk.sv
// Checker for itx_ctx_bank: port-level rules on ownership of run, wake
// and dead, and on the reserved read bits. Bound to every instance.
module itx_ctx_bank_chk
    import itx_ctx_pkg::*;
#(
    parameter int NUM_CTX = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               sw_wr_i,
    input logic [DATA_W-1:0]  sw_rdata_o,
    input logic [NUM_CTX-1:0] hw_fetch_i,
    input logic [NUM_CTX-1:0] hw_fatal_i,
    input logic [NUM_CTX-1:0] ctx_run_o,
    input logic [NUM_CTX-1:0] ctx_wake_o,
    input logic [NUM_CTX-1:0] ctx_dead_o
);

    localparam logic [DATA_W-1:0] RSVD_MASK = 32'h0000_63E0;

    AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_rdata_o & RSVD_MASK) == '0); // R2

    AST_RUN_SW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sw_wr_i |=> $stable(ctx_run_o)); // R3

    AST_WAKE_FETCH_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_fetch_i != '0 |=> (ctx_wake_o & $past(hw_fetch_i)) == '0); // R4

    AST_WAKE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sw_wr_i |=> (ctx_wake_o & ~$past(ctx_wake_o)) == '0); // R4

    AST_DEAD_ON_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_fatal_i != '0 |=> (ctx_dead_o & $past(hw_fatal_i)) == $past(hw_fatal_i)); // R5

    AST_DEAD_HW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_fatal_i == '0 |=> (ctx_dead_o & ~$past(ctx_dead_o)) == '0); // R5

endmodule

bind itx_ctx_bank itx_ctx_bank_chk #(.NUM_CTX(NUM_CTX)) u_chk (.*);

// File: tb/test_itx_ctx_bank.sv
// Bench: behavioural model of all contexts, compared after every clock.
module test_itx_ctx_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] sw_addr = '0;
    logic        sw_wr = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic [7:0]  hw_fetch = '0, hw_fatal = '0, hw_active = '0, hw_evt_wr = '0;
    logic [39:0] hw_evt_code = '0;
    logic [1:0]  cyc_sec = '0;
    logic [12:0] cyc_cnt = '0;
    logic [7:0]  run_o, wake_o, dead_o, allow_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    itx_ctx_bank i_itx_ctx_bank (
        .clk_i(clk), .rst_ni(rst_n), .sw_addr_i(sw_addr), .sw_wr_i(sw_wr),
        .sw_wdata_i(sw_wdata), .sw_rdata_o(sw_rdata), .hw_fetch_i(hw_fetch),
        .hw_fatal_i(hw_fatal), .hw_active_i(hw_active), .hw_evt_wr_i(hw_evt_wr),
        .hw_evt_code_i(hw_evt_code), .cyc_sec_lo_i(cyc_sec), .cyc_count_i(cyc_cnt),
        .ctx_run_o(run_o), .ctx_wake_o(wake_o), .ctx_dead_o(dead_o),
        .ctx_tx_allow_o(allow_o)
    );

    // Reference state
    logic        m_run [8], m_wake [8], m_dead [8], m_act [8], m_cme [8], m_hit [8];
    logic [14:0] m_cm [8];
    logic [4:0]  m_evt [8];

    function automatic bit stamp_eq(int n);
        return {cyc_sec, cyc_cnt} == m_cm[n];
    endfunction

    always @(posedge clk) begin
        for (int n = 0; n < 8; n++) begin
            if (!rst_n) begin
                m_run[n] = 0; m_wake[n] = 0; m_dead[n] = 0; m_act[n] = 0;
                m_cme[n] = 0; m_hit[n] = 0; m_cm[n] = '0; m_evt[n] = '0;
            end else begin
                bit s, c, rise, nh;
                s = sw_wr && (int'(sw_addr) == 'h200 + 16 * n);
                c = sw_wr && (int'(sw_addr) == 'h204 + 16 * n);
                rise = hw_active[n] && !m_act[n];
                nh = m_cme[n] ? (m_hit[n] || stamp_eq(n)) : 1'b0;
                if (hw_fatal[n]) m_dead[n] = 1;
                else if (c && sw_wdata[15]) m_dead[n] = 0;
                if (s && sw_wdata[15]) m_run[n] = 1;
                else if (c && sw_wdata[15]) m_run[n] = 0;
                if (s && sw_wdata[31]) m_cme[n] = 1;
                else if (c && sw_wdata[31]) m_cme[n] = 0;
                else if (rise) m_cme[n] = 0;
                if (s) m_cm[n] = m_cm[n] | sw_wdata[30:16];
                if (c) m_cm[n] = m_cm[n] & ~sw_wdata[30:16];
                if (hw_fetch[n]) m_wake[n] = 0;
                else if (s && sw_wdata[12]) m_wake[n] = 1;
                if (hw_evt_wr[n]) m_evt[n] = hw_evt_code[n*5 +: 5];
                m_act[n] = hw_active[n];
                m_hit[n] = nh;
            end
        end
    end

    function automatic logic [31:0] exp_word(int n);
        return {m_cme[n], m_cm[n], m_run[n], 2'b00, m_wake[n], m_dead[n],
                m_act[n], 5'b00000, m_evt[n]};
    endfunction

    function automatic logic [31:0] exp_rd();
        for (int n = 0; n < 8; n++)
            if (int'(sw_addr) == 'h200 + 16 * n || int'(sw_addr) == 'h204 + 16 * n)
                return exp_word(n);
        return '0;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock, then compare every output with the model.
    task automatic tick(string tag);
        logic [7:0] er, ew, ed, ea;
        @(posedge clk);
        #1;
        for (int n = 0; n < 8; n++) begin
            er[n] = m_run[n]; ew[n] = m_wake[n]; ed[n] = m_dead[n];
            ea[n] = m_run[n] && !m_dead[n] && (!m_cme[n] || stamp_eq(n) || m_hit[n]);
        end
        chk(tag, "rdata", sw_rdata, exp_rd());
        chk(tag, "run", {24'd0, run_o}, {24'd0, er});
        chk(tag, "wake", {24'd0, wake_o}, {24'd0, ew});
        chk(tag, "dead", {24'd0, dead_o}, {24'd0, ed});
        chk(tag, "allow", {24'd0, allow_o}, {24'd0, ea});
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
        sw_addr = a; sw_wdata = d; sw_wr = 1'b1;
        tick(tag);
        sw_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, string tag);
        sw_addr = a; sw_wr = 1'b0;
        tick(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R11: reset state of every context
        rd(12'h200, "R11");
        for (int n = 0; n < 8; n++) rd(12'(('h200 + 16 * n)), "R11");
        rst_n = 1'b1;
        rd(12'h274, "R11");

        // R1: decode, unused offsets and out-of-range address
        wr(12'h230, 32'h0000_8000, "R1");
        wr(12'h238, 32'hFFFF_FFFF, "R1");
        wr(12'h23C, 32'hFFFF_FFFF, "R1");
        wr(12'h280, 32'hFFFF_FFFF, "R1");
        rd(12'h238, "R1"); rd(12'h280, "R1"); rd(12'h234, "R1");

        // R2: all ones at set; reserved and engine bits stay zero
        wr(12'h220, 32'hFFFF_FFFF, "R2");
        rd(12'h220, "R2"); rd(12'h224, "R2");

        // R3: clear run through the clear address
        wr(12'h234, 32'h0000_8000, "R3");
        rd(12'h230, "R3");

        // R4: wake set, fetch clears, collision, clear address ignored
        wr(12'h210, 32'h0000_1000, "R4");
        wr(12'h214, 32'h0000_1000, "R4");
        rd(12'h210, "R4");
        hw_fetch = 8'h02; rd(12'h210, "R4"); hw_fetch = '0;
        hw_fetch = 8'h02; wr(12'h210, 32'h0000_1000, "R4"); hw_fetch = '0;
        rd(12'h210, "R4");

        // R5: fatal sets dead, run clear clears it, fatal wins collision
        wr(12'h260, 32'h0000_8800, "R5");
        hw_fatal = 8'h40; rd(12'h260, "R5"); hw_fatal = '0;
        wr(12'h264, 32'h0000_8000, "R5");
        wr(12'h260, 32'h0000_8000, "R5");
        hw_fatal = 8'h40; rd(12'h260, "R5"); hw_fatal = '0;
        hw_fatal = 8'h40; wr(12'h264, 32'h0000_8000, "R5"); hw_fatal = '0;
        rd(12'h260, "R5");

        // R6: active follows the engine level; software ignored
        wr(12'h270, 32'h0000_0400, "R6");
        hw_active = 8'h80; rd(12'h270, "R6");
        wr(12'h274, 32'h0000_0400, "R6");
        hw_active = 8'h00; rd(12'h270, "R6");

        // R7: event code from the engine; software ignored
        hw_evt_wr = 8'h01; hw_evt_code = 40'h11; rd(12'h200, "R7");
        hw_evt_wr = '0;
        wr(12'h204, 32'h0000_001F, "R7");
        wr(12'h200, 32'h0000_000E, "R7");
        rd(12'h204, "R7");

        // R8: cycle-match field set and clear per bit
        wr(12'h210, 32'h5A5A_0000, "R8");
        wr(12'h214, 32'h1248_0000, "R8");
        wr(12'h210, 32'h0001_0000, "R8");
        rd(12'h214, "R8");

        // R9: enable cleared on active edge; software set wins collision
        wr(12'h240, 32'h8000_0000, "R9");
        hw_active = 8'h10; rd(12'h240, "R9");
        wr(12'h240, 32'h8000_0000, "R9");
        rd(12'h240, "R9");
        hw_active = 8'h00; rd(12'h240, "R9");
        hw_active = 8'h10; wr(12'h240, 32'h8000_0000, "R9");
        rd(12'h240, "R9");
        hw_active = 8'h00; wr(12'h244, 32'h8000_0000, "R9");

        // R10: start gate opens on stamp match, then stays open
        cyc_sec = 2'd0; cyc_cnt = 13'h0ABB;
        wr(12'h250, 32'h8000_0000 | (32'h2ABC << 16) | 32'h8000, "R10");
        rd(12'h250, "R10");
        cyc_sec = 2'd1; cyc_cnt = 13'h0ABB; rd(12'h250, "R10");
        cyc_cnt = 13'h0ABC; rd(12'h250, "R10");
        cyc_cnt = 13'h0ABD; rd(12'h250, "R10");
        rd(12'h250, "R10");
        hw_active = 8'h20; rd(12'h250, "R10");
        hw_fatal = 8'h20; rd(12'h250, "R10"); hw_fatal = '0;
        hw_active = '0; rd(12'h250, "R10");

        // R12: mixed traffic across all contexts
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r0, r1, r2, r3;
            r0 = $urandom(); r1 = $urandom(); r2 = $urandom(); r3 = $urandom();
            sw_wr = (r0[1:0] == 2'b00);
            sw_addr = 12'('h200 + (r0[7:4] % 9) * 16 + (r0[9:8] % 3) * 4);
            sw_wdata = r1;
            hw_fetch = r2[7:0] & r3[7:0];
            hw_fatal = r2[15:8] & r3[15:8] & r2[23:16];
            if (r0[12:10] == 3'd0) hw_active = hw_active ^ r3[23:16];
            hw_evt_wr = r2[31:24] & r3[31:24];
            hw_evt_code = {r1[7:0], r2, r3[31:24]} ^ {8'd0, r0};
            cyc_sec = r0[14:13];
            cyc_cnt = {11'd0, r0[16:15]};
            if (r0[20:17] == 4'd0) rst_n = 1'b0;
            tick("R12");
            rst_n = 1'b1;
        end
        sw_wr = 1'b0;
        hw_fetch = '0; hw_fatal = '0; hw_evt_wr = '0;
        rd(12'h200, "R12");
        finish_run();
    end

endmodule